// File: doc/BRIEF.md
# Dual-Field Elliptic Curve Point Arithmetic Unit

This block performs one elliptic-curve group operation per request on 8-bit field elements. A field selector picks either the binary extension field GF(2^8) or the prime field GF(251). An operation selector picks either point addition or point doubling. The chosen field and operation apply to the whole request.

Points are given in projective form. In the binary field the unit uses López–Dahab coordinates (x = X/Z, y = Y/Z^2). In the prime field it uses Jacobian coordinates (x = X/Z^2, y = Y/Z^3). Addition is mixed: it combines the projective point with a second point given in affine form. Doubling uses only the projective point.

Inside, a microcoded sequencer steps through a fixed program for the selected mode. Each step issues one operation to a single shared field ALU, which can multiply, square, add or subtract. The ALU reads and writes a small register file. The result is a projective point, and a done flag marks it valid. Scalar multiplication, inversion and conversion back to affine form are left to the surrounding logic.

Top module: `ecpu_point_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` and `busy` are 0 and `res_x`, `res_y` and `res_z` are 0.
- R2: A `start` pulse seen while `busy` is 0 captures every operand and both selectors. `busy` rises and `done` falls on the next cycle. A `start` seen while `busy` is 1 is ignored: the running operation completes unchanged, with its own latency and result.
- R3: With `field_sel`=0 and `op_sel`=0, the unit adds the López–Dahab point (px,py,pz) and the affine point (qx,qy) on y^2 + xy = x^3 + a·x^2 + b over GF(2^8). Field addition is XOR and the reduction polynomial is x^8+x^4+x^3+x+1 (0x11B). The affine form of the projective result equals the affine sum.
- R4: With `field_sel`=0 and `op_sel`=1, the unit doubles the López–Dahab point on the same curve, using `curve_b`. The affine form of the result equals the affine double.
- R5: With `field_sel`=1 and `op_sel`=0, the unit adds the Jacobian point (px,py,pz) and the affine point (qx,qy) on y^2 = x^3 + a·x + b mod 251. The affine form of the result equals the affine sum.
- R6: With `field_sel`=1 and `op_sel`=1, the unit doubles the Jacobian point on the prime curve. The affine form of the result equals the affine double.
- R7: `done` rises a fixed number of cycles after the clock edge that accepts `start`: 23 for binary add, 14 for binary double, 18 for prime add and 23 for prime double. `busy` and `done` are never both 1.
- R8: Doubling a point whose Z coordinate is 0 returns `res_z` = 0, the point at infinity, in both fields.
- R9: Once `done` is 1, it and the result stay unchanged until the next accepted `start`.
- R10: Selector encodings are `field_sel` 0 = binary and 1 = prime, and `op_sel` 0 = add and 1 = double.
- R11: In prime mode, when every operand is below 251, each result coordinate is below 251.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation (accepted only when idle) |
| field_sel | input | 1 | 0 = GF(2^8), 1 = GF(251) |
| op_sel | input | 1 | 0 = point addition, 1 = point doubling |
| px | input | 8 | Projective X of first point |
| py | input | 8 | Projective Y of first point |
| pz | input | 8 | Projective Z of first point |
| qx | input | 8 | Affine x of second point (add only) |
| qy | input | 8 | Affine y of second point (add only) |
| curve_a | input | 8 | Curve coefficient a |
| curve_b | input | 8 | Curve coefficient b (binary doubling only) |
| res_x | output | 8 | Projective X of result |
| res_y | output | 8 | Projective Y of result |
| res_z | output | 8 | Projective Z of result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid |

## Verification
The assertions check the sequencing contract on every cycle: a request is accepted only when idle, the mode does not change while busy, `busy` and `done` are exclusive, the step index stays inside the program length, `done` and the results hold once done is set, and prime results stay inside the field.

Only the bench's scenarios can show the arithmetic itself. The bench converts each projective result back to affine form and compares it with an independent affine model for both fields and both operations. Those scenarios also cover the exact latency of each mode, a request arriving while busy, and doubling a point whose Z is zero.

// File: rtl/ecpu_pkg.sv
package ecpu_pkg;
    localparam int W      = 8;
    localparam int PRIME  = 251;
    localparam logic [W:0] POLY = 9'h11B;
    localparam int NREG   = 16;
    localparam int RAW    = $clog2(NREG);
    localparam int STEPW  = 5;

    // register file map: operands, coefficients, temporaries 6..9, results
    localparam int R_PX = 0;
    localparam int R_PY = 1;
    localparam int R_PZ = 2;
    localparam int R_QX = 3;
    localparam int R_QY = 4;
    localparam int R_CA = 5;
    localparam int R_OX = 10;
    localparam int R_OY = 11;
    localparam int R_OZ = 12;
    localparam int R_CB = 13;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL, ALU_SQR} alu_op_e;
    // encoding is {field_sel, op_sel}
    typedef enum logic [1:0] {MODE_BADD, MODE_BDBL, MODE_PADD, MODE_PDBL} mode_e;

    typedef struct packed {
        alu_op_e        op;
        logic [RAW-1:0] dst;
        logic [RAW-1:0] sa;
        logic [RAW-1:0] sb;
    } ustep_t;

    function automatic logic [W-1:0] gf2_reduce(input logic [2*W-2:0] p);
        logic [2*W-2:0] r;
        r = p;
        for (int i = 2*W-2; i >= W; i--)
            if (r[i]) r = r ^ ({{(W-2){1'b0}}, POLY} << (i-W));
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] gf2_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-2:0] p;
        p = '0;
        for (int i = 0; i < W; i++)
            if (b[i]) p = p ^ ({{(W-1){1'b0}}, a} << i);
        return gf2_reduce(p);
    endfunction

    // squaring in characteristic two only interleaves zeros
    function automatic logic [W-1:0] gf2_sqr(input logic [W-1:0] a);
        logic [2*W-2:0] p;
        p = '0;
        for (int i = 0; i < W; i++) p[2*i] = a[i];
        return gf2_reduce(p);
    endfunction

    function automatic logic [W-1:0] fp_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p;
        p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        return W'(p % (2*W)'(PRIME));
    endfunction

    function automatic logic [W-1:0] fp_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (W+1)'(PRIME)) s = s - (W+1)'(PRIME);
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] fp_sub(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        if (a >= b) s = {1'b0, a} - {1'b0, b};
        else        s = {1'b0, a} + (W+1)'(PRIME) - {1'b0, b};
        return s[W-1:0];
    endfunction

    function automatic ustep_t mk(input alu_op_e op, input int d, input int a, input int b);
        ustep_t s;
        s.op  = op;
        s.dst = RAW'(d);
        s.sa  = RAW'(a);
        s.sb  = RAW'(b);
        return s;
    endfunction

    function automatic logic [STEPW-1:0] prog_len(input mode_e m);
        case (m)
            MODE_BADD: return STEPW'(23);
            MODE_BDBL: return STEPW'(14);
            MODE_PADD: return STEPW'(18);
            default:   return STEPW'(23);
        endcase
    endfunction

    // registers: 0 X, 1 Y, 2 Z, 3 qx, 4 qy, 5 a, 13 b, 6..9 temps, 10..12 result
    function automatic ustep_t ucode(input mode_e m, input logic [STEPW-1:0] i);
        ustep_t s;
        s = mk(ALU_ADD, 6, 6, 6);
        case (m)
            MODE_BADD: case (i)
                5'd0:  s = mk(ALU_SQR, 6, 2, 2);
                5'd1:  s = mk(ALU_MUL, 7, 4, 6);
                5'd2:  s = mk(ALU_ADD, 7, 7, 1);
                5'd3:  s = mk(ALU_MUL, 8, 3, 2);
                5'd4:  s = mk(ALU_ADD, 8, 8, 0);
                5'd5:  s = mk(ALU_MUL, 9, 2, 8);
                5'd6:  s = mk(ALU_MUL, 6, 5, 6);
                5'd7:  s = mk(ALU_ADD, 6, 9, 6);
                5'd8:  s = mk(ALU_SQR, 8, 8, 8);
                5'd9:  s = mk(ALU_MUL, 8, 8, 6);
                5'd10: s = mk(ALU_SQR, 12, 9, 9);
                5'd11: s = mk(ALU_MUL, 9, 7, 9);
                5'd12: s = mk(ALU_SQR, 10, 7, 7);
                5'd13: s = mk(ALU_ADD, 10, 10, 8);
                5'd14: s = mk(ALU_ADD, 10, 10, 9);
                5'd15: s = mk(ALU_MUL, 6, 3, 12);
                5'd16: s = mk(ALU_ADD, 6, 10, 6);
                5'd17: s = mk(ALU_ADD, 7, 3, 4);
                5'd18: s = mk(ALU_SQR, 8, 12, 12);
                5'd19: s = mk(ALU_MUL, 7, 7, 8);
                5'd20: s = mk(ALU_ADD, 9, 9, 12);
                5'd21: s = mk(ALU_MUL, 9, 9, 6);
                5'd22: s = mk(ALU_ADD, 11, 9, 7);
                default: ;
            endcase
            MODE_BDBL: case (i)
                5'd0:  s = mk(ALU_SQR, 6, 0, 0);
                5'd1:  s = mk(ALU_SQR, 7, 2, 2);
                5'd2:  s = mk(ALU_MUL, 12, 6, 7);
                5'd3:  s = mk(ALU_SQR, 6, 6, 6);
                5'd4:  s = mk(ALU_SQR, 7, 7, 7);
                5'd5:  s = mk(ALU_MUL, 7, 13, 7);
                5'd6:  s = mk(ALU_ADD, 10, 6, 7);
                5'd7:  s = mk(ALU_MUL, 8, 5, 12);
                5'd8:  s = mk(ALU_SQR, 9, 1, 1);
                5'd9:  s = mk(ALU_ADD, 8, 8, 9);
                5'd10: s = mk(ALU_ADD, 8, 8, 7);
                5'd11: s = mk(ALU_MUL, 8, 10, 8);
                5'd12: s = mk(ALU_MUL, 9, 7, 12);
                5'd13: s = mk(ALU_ADD, 11, 9, 8);
                default: ;
            endcase
            MODE_PADD: case (i)
                5'd0:  s = mk(ALU_SQR, 6, 2, 2);
                5'd1:  s = mk(ALU_MUL, 7, 3, 6);
                5'd2:  s = mk(ALU_MUL, 6, 6, 2);
                5'd3:  s = mk(ALU_MUL, 6, 4, 6);
                5'd4:  s = mk(ALU_SUB, 7, 7, 0);
                5'd5:  s = mk(ALU_SUB, 6, 6, 1);
                5'd6:  s = mk(ALU_MUL, 12, 2, 7);
                5'd7:  s = mk(ALU_SQR, 8, 7, 7);
                5'd8:  s = mk(ALU_MUL, 9, 8, 7);
                5'd9:  s = mk(ALU_MUL, 8, 0, 8);
                5'd10: s = mk(ALU_SQR, 10, 6, 6);
                5'd11: s = mk(ALU_SUB, 10, 10, 9);
                5'd12: s = mk(ALU_SUB, 10, 10, 8);
                5'd13: s = mk(ALU_SUB, 10, 10, 8);
                5'd14: s = mk(ALU_SUB, 7, 8, 10);
                5'd15: s = mk(ALU_MUL, 7, 6, 7);
                5'd16: s = mk(ALU_MUL, 9, 1, 9);
                5'd17: s = mk(ALU_SUB, 11, 7, 9);
                default: ;
            endcase
            default: case (i)
                5'd0:  s = mk(ALU_SQR, 6, 1, 1);
                5'd1:  s = mk(ALU_MUL, 7, 0, 6);
                5'd2:  s = mk(ALU_ADD, 7, 7, 7);
                5'd3:  s = mk(ALU_ADD, 7, 7, 7);
                5'd4:  s = mk(ALU_SQR, 8, 2, 2);
                5'd5:  s = mk(ALU_SQR, 8, 8, 8);
                5'd6:  s = mk(ALU_MUL, 8, 5, 8);
                5'd7:  s = mk(ALU_SQR, 9, 0, 0);
                5'd8:  s = mk(ALU_ADD, 8, 8, 9);
                5'd9:  s = mk(ALU_ADD, 8, 8, 9);
                5'd10: s = mk(ALU_ADD, 8, 8, 9);
                5'd11: s = mk(ALU_MUL, 12, 1, 2);
                5'd12: s = mk(ALU_ADD, 12, 12, 12);
                5'd13: s = mk(ALU_SQR, 10, 8, 8);
                5'd14: s = mk(ALU_SUB, 10, 10, 7);
                5'd15: s = mk(ALU_SUB, 10, 10, 7);
                5'd16: s = mk(ALU_SUB, 9, 7, 10);
                5'd17: s = mk(ALU_MUL, 9, 8, 9);
                5'd18: s = mk(ALU_SQR, 6, 6, 6);
                5'd19: s = mk(ALU_ADD, 6, 6, 6);
                5'd20: s = mk(ALU_ADD, 6, 6, 6);
                5'd21: s = mk(ALU_ADD, 6, 6, 6);
                5'd22: s = mk(ALU_SUB, 11, 9, 6);
                default: ;
            endcase
        endcase
        return s;
    endfunction
endpackage

// File: rtl/ecpu_field_alu.sv
module ecpu_field_alu
    import ecpu_pkg::*;
(
    input  logic          prime,
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);
    always_comb begin
        case (op)
            ALU_ADD: y = prime ? fp_add(a, b) : (a ^ b);
            ALU_SUB: y = prime ? fp_sub(a, b) : (a ^ b);
            ALU_MUL: y = prime ? fp_mul(a, b) : gf2_mul(a, b);
            default: y = prime ? fp_mul(a, a) : gf2_sqr(a);
        endcase
    end
endmodule

// File: rtl/ecpu_useq.sv
module ecpu_useq
    import ecpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  mode_e   mode_in,
    output logic    busy,
    output logic    done,
    output mode_e   mode_q,
    output ustep_t  step
);
    logic [STEPW-1:0] idx;
    logic             last;

    assign last = (idx == prog_len(mode_q) - STEPW'(1));
    assign step = ucode(mode_q, idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            idx    <= '0;
            mode_q <= MODE_BADD;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            idx    <= '0;
            mode_q <= mode_in;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                idx <= idx + STEPW'(1);
            end
        end
    end

    a_r2_accept_idle: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy && !done);
    a_r2_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(mode_q));
    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    a_r7_step_in_program: assert property (@(posedge clk) disable iff (rst)
        busy |-> idx < prog_len(mode_q));
    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done);
endmodule

// File: rtl/ecpu_regfile.sv
module ecpu_regfile
    import ecpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [NREG-1:0] ld_mask,
    input  logic [W-1:0]    ld_val [NREG],
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [W-1:0]    wdata,
    input  logic [RAW-1:0]  ra,
    input  logic [RAW-1:0]  rb,
    output logic [W-1:0]    rd_a,
    output logic [W-1:0]    rd_b,
    output logic [W-1:0]    out_x,
    output logic [W-1:0]    out_y,
    output logic [W-1:0]    out_z
);
    logic [W-1:0] rf [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)                        r <= '0;
            else if (load && ld_mask[i])    r <= ld_val[i];
            else if (we && waddr == RAW'(i)) r <= wdata;
        end
        assign rf[i] = r;
    end

    assign rd_a  = rf[ra];
    assign rd_b  = rf[rb];
    assign out_x = rf[R_OX];
    assign out_y = rf[R_OY];
    assign out_z = rf[R_OZ];
endmodule

// File: rtl/ecpu_point_unit.sv
module ecpu_point_unit
    import ecpu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         field_sel,
    input  logic         op_sel,
    input  logic [7:0]   px,
    input  logic [7:0]   py,
    input  logic [7:0]   pz,
    input  logic [7:0]   qx,
    input  logic [7:0]   qy,
    input  logic [7:0]   curve_a,
    input  logic [7:0]   curve_b,
    output logic [7:0]   res_x,
    output logic [7:0]   res_y,
    output logic [7:0]   res_z,
    output logic         busy,
    output logic         done
);
    localparam logic [NREG-1:0] LD_MASK = NREG'((1 << R_PX) | (1 << R_PY) | (1 << R_PZ) |
                                                (1 << R_QX) | (1 << R_QY) | (1 << R_CA) |
                                                (1 << R_CB));

    mode_e        mode_q;
    ustep_t       step;
    logic [W-1:0] opa, opb, alu_y;
    logic [W-1:0] ld_val [NREG];
    logic         prime_q;

    always_comb begin
        for (int i = 0; i < NREG; i++) ld_val[i] = '0;
        ld_val[R_PX] = px;
        ld_val[R_PY] = py;
        ld_val[R_PZ] = pz;
        ld_val[R_QX] = qx;
        ld_val[R_QY] = qy;
        ld_val[R_CA] = curve_a;
        ld_val[R_CB] = curve_b;
    end

    assign prime_q = (mode_q == MODE_PADD) || (mode_q == MODE_PDBL);

    ecpu_useq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode_in (mode_e'({field_sel, op_sel})),
        .busy    (busy),
        .done    (done),
        .mode_q  (mode_q),
        .step    (step)
    );

    ecpu_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .load    (start && !busy),
        .ld_mask (LD_MASK),
        .ld_val  (ld_val),
        .we      (busy),
        .waddr   (step.dst),
        .wdata   (alu_y),
        .ra      (step.sa),
        .rb      (step.sb),
        .rd_a    (opa),
        .rd_b    (opb),
        .out_x   (res_x),
        .out_y   (res_y),
        .out_z   (res_z)
    );

    ecpu_field_alu u_alu (
        .prime (prime_q),
        .op    (step.op),
        .a     (opa),
        .b     (opb),
        .y     (alu_y)
    );

    a_r9_result_stable: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> $stable(res_x) && $stable(res_y) && $stable(res_z));
    a_r11_prime_in_field: assert property (@(posedge clk) disable iff (rst)
        done && prime_q |-> (res_x < 8'(PRIME)) && (res_y < 8'(PRIME)) && (res_z < 8'(PRIME)));
endmodule

// File: tb/ecpu_point_unit_bench.sv
module ecpu_point_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] BA = 8'h01, BB = 8'h2B;   // binary curve
    localparam logic [7:0] PA = 8'd2,  PB = 8'd3;    // prime curve
    // {field, op, point index, second point index, Z}
    localparam logic [25:0] VEC [8] = '{
        {1'b0, 1'b0, 8'd3,  8'd40, 8'h05},
        {1'b0, 1'b0, 8'd10, 8'd77, 8'h9C},
        {1'b0, 1'b1, 8'd5,  8'd0,  8'h01},
        {1'b0, 1'b1, 8'd22, 8'd0,  8'hE7},
        {1'b1, 1'b0, 8'd2,  8'd50, 8'd1},
        {1'b1, 1'b0, 8'd17, 8'd90, 8'd123},
        {1'b1, 1'b1, 8'd4,  8'd0,  8'd3},
        {1'b1, 1'b1, 8'd60, 8'd0,  8'd240}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, field_sel = 1'b0, op_sel = 1'b0;
    logic [7:0] px = 0, py = 0, pz = 0, qx = 0, qy = 0, ca = 0, cb = 0;
    logic [7:0] rx, ry, rz;
    logic busy, done;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecpu_point_unit u_ecpu_point_unit (
        .clk(clk), .rst(rst), .start(start), .field_sel(field_sel), .op_sel(op_sel),
        .px(px), .py(py), .pz(pz), .qx(qx), .qy(qy), .curve_a(ca), .curve_b(cb),
        .res_x(rx), .res_y(ry), .res_z(rz), .busy(busy), .done(done)
    );

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ a;
            a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
        end
        return r;
    endfunction
    function automatic logic [7:0] fmul(input bit f, input logic [7:0] a, input logic [7:0] b);
        return f ? 8'((16'(a) * 16'(b)) % 16'd251) : bmul(a, b);
    endfunction
    function automatic logic [7:0] fadd(input bit f, input logic [7:0] a, input logic [7:0] b);
        return f ? 8'((9'(a) + 9'(b)) % 9'd251) : (a ^ b);
    endfunction
    function automatic logic [7:0] fsub(input bit f, input logic [7:0] a, input logic [7:0] b);
        return f ? 8'((9'(a) + 9'd251 - 9'(b)) % 9'd251) : (a ^ b);
    endfunction
    function automatic logic [7:0] finv(input bit f, input logic [7:0] a);
        for (int i = 1; i < 256; i++) if (fmul(f, a, 8'(i)) == 8'd1) return 8'(i);
        return 8'd0;
    endfunction
    function automatic bit on_curve(input bit f, input logic [7:0] x, input logic [7:0] y);
        logic [7:0] x2 = fmul(f, x, x);
        if (f) return fmul(1, y, y) == fadd(1, fadd(1, fmul(1, x2, x), fmul(1, PA, x)), PB);
        return (bmul(y, y) ^ bmul(x, y)) == (bmul(x2, x) ^ bmul(BA, x2) ^ BB);
    endfunction

    task automatic find_pt(input bit f, input int n, output logic [7:0] x, output logic [7:0] y);
        int c = 0;
        bit found = 0;
        int lim = f ? 251 : 256;
        x = 0; y = 0;
        for (int xi = 1; xi < lim; xi++)
            for (int yi = 1; yi < lim; yi++)
                if (!found && on_curve(f, 8'(xi), 8'(yi))) begin
                    if (c == n) begin x = 8'(xi); y = 8'(yi); found = 1; end
                    c++;
                end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input bit f, input bit op, input logic [7:0] x1, input logic [7:0] y1,
                         input logic [7:0] x2, input logic [7:0] y2,
                         output logic [7:0] ex, output logic [7:0] ey);
        logic [7:0] lam;
        if (!op) begin
            lam = fmul(f, fsub(f, y2, y1), finv(f, fsub(f, x2, x1)));
            if (f) begin
                ex = fsub(1, fsub(1, fmul(1, lam, lam), x1), x2);
                ey = fsub(1, fmul(1, lam, fsub(1, x1, ex)), y1);
            end else begin
                ex = bmul(lam, lam) ^ lam ^ x1 ^ x2 ^ BA;
                ey = bmul(lam, x1 ^ ex) ^ ex ^ y1;
            end
        end else if (f) begin
            lam = fmul(1, fadd(1, fadd(1, fadd(1, fmul(1, x1, x1), fmul(1, x1, x1)),
                                       fmul(1, x1, x1)), PA), finv(1, fadd(1, y1, y1)));
            ex = fsub(1, fsub(1, fmul(1, lam, lam), x1), x1);
            ey = fsub(1, fmul(1, lam, fsub(1, x1, ex)), y1);
        end else begin
            lam = x1 ^ bmul(y1, finv(0, x1));
            ex = bmul(lam, lam) ^ lam ^ BA;
            ey = bmul(x1, x1) ^ bmul(lam ^ 8'd1, ex);
        end
    endtask

    // drive one request; lat counts clock edges from the accepting edge to done
    task automatic launch(input bit f, input bit op, input logic [7:0] x1, input logic [7:0] y1,
                          input logic [7:0] z, input logic [7:0] x2, input logic [7:0] y2);
        logic [7:0] z2 = fmul(f, z, z);
        @(negedge clk);
        field_sel = f; op_sel = op; pz = z; qx = x2; qy = y2;
        px = f ? fmul(1, x1, z2) : bmul(x1, z);
        py = f ? fmul(1, y1, fmul(1, z2, z)) : bmul(y1, z2);
        ca = f ? PA : BA; cb = f ? PB : BB;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 64) begin @(negedge clk); lat++; end
    endtask

    task automatic check_result(input bit f, input string req, input logic [7:0] ex,
                                input logic [7:0] ey);
        logic [7:0] zi, zi2;
        chk(rz != 8'd0, {req, " result not infinity"}, rz, 1);
        if (rz != 8'd0) begin
            zi  = finv(f, rz);
            zi2 = fmul(f, zi, zi);
            if (f) begin
                chk(fmul(1, rx, zi2) == ex, {req, " affine x"}, fmul(1, rx, zi2), ex);
                chk(fmul(1, ry, fmul(1, zi2, zi)) == ey, {req, " affine y"},
                    fmul(1, ry, fmul(1, zi2, zi)), ey);
            end else begin
                chk(bmul(rx, zi) == ex, {req, " affine x"}, bmul(rx, zi), ex);
                chk(bmul(ry, zi2) == ey, {req, " affine y"}, bmul(ry, zi2), ey);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog actual=hang expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] x1, y1, x2, y2, ex, ey, hold_x;
        int lat, exp_lat, qi;
        string req;

        repeat (3) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1 flags in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1 flags after reset", {busy, done}, 0);
        chk(rx == 0 && ry == 0 && rz == 0, "R1 result after reset", {rx, ry, rz}, 0);

        // table walk: one vector per mode pattern, field_sel/op_sel per R10
        for (int v = 0; v < 8; v++) begin
            bit f  = VEC[v][25];
            bit op = VEC[v][24];
            find_pt(f, int'(VEC[v][23:16]), x1, y1);
            x2 = 0; y2 = 0;
            if (!op) begin
                qi = int'(VEC[v][15:8]);
                find_pt(f, qi, x2, y2);
                while (x2 == x1) begin qi += 2; find_pt(f, qi, x2, y2); end
            end
            model(f, op, x1, y1, x2, y2, ex, ey);
            case ({f, op})
                2'b00: begin req = "R3,R10 badd"; exp_lat = 23; end
                2'b01: begin req = "R4,R10 bdbl"; exp_lat = 14; end
                2'b10: begin req = "R5,R10 padd"; exp_lat = 18; end
                default: begin req = "R6,R10 pdbl"; exp_lat = 23; end
            endcase
            launch(f, op, x1, y1, VEC[v][7:0], x2, y2);
            chk(busy == 1'b1 && done == 1'b0, "R2 busy after accept", {busy, done}, 2);
            wait_done(lat);
            chk(lat == exp_lat, {"R7 latency ", req}, lat, exp_lat);
            check_result(f, req, ex, ey);
            if (f) chk(rx < 251 && ry < 251 && rz < 251, "R11 prime range", rx, 250);
            if (v == 0) begin
                hold_x = rx;
                repeat (5) @(negedge clk);
                chk(done == 1'b1, "R9 done holds", done, 1);
                chk(rx == hold_x, "R9 result holds", rx, hold_x);
            end
        end

        // R8: doubling with Z = 0 in each field
        for (int f = 0; f < 2; f++) begin
            @(negedge clk);
            field_sel = f[0]; op_sel = 1'b1; px = 8'd7; py = 8'd19; pz = 8'd0;
            ca = f[0] ? PA : BA; cb = f[0] ? PB : BB;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(lat);
            chk(done == 1'b1, "R8 double of infinity completes", done, 1);
            chk(rz == 8'd0, "R8 double of infinity gives Z=0", rz, 0);
        end

        // R2: a second start while busy is ignored
        find_pt(0, 12, x1, y1);
        find_pt(0, 61, x2, y2);
        if (x2 == x1) find_pt(0, 63, x2, y2);
        model(0, 0, x1, y1, x2, y2, ex, ey);
        launch(0, 0, x1, y1, 8'h3A, x2, y2);
        lat = 0;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
            if (lat == 3) begin
                field_sel = 1'b1; op_sel = 1'b1; px = 8'd9; pz = 8'd4; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(lat == 23, "R2 latency unchanged by busy start", lat, 23);
        check_result(0, "R2 busy start ignored", ex, ey);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule